// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter

This block lets several bus initiators share a single target port of a Wishbone-style bus. A registered grant index picks one initiator. That initiator's address, write data, byte selects, strobe, write enable, lock and burst tags drive the shared bus. Only the granted initiator sees the target's responses. When the grant is released, it rotates to the next requesting initiator in cyclic index order, so every initiator is eventually served.

Initiators are adapted one at a time through parameters. An initiator with no lock line behaves as if lock followed its cycle line. An initiator with no cycle-type or burst-extension lines drives the classic and linear codes. An initiator whose select granularity is coarser than the shared bus has each select bit repeated across the matching bus lanes. If the target has no stall line, a stall is derived from the acknowledge.

Top module: `bus_rr_arbiter`

## Requirements
- R1: After reset the grant index is 0, and the shared bus cycle line equals initiator 0's cycle line.
- R2: The shared bus address, write data, strobe, write enable and cycle come from the granted initiator.
- R3: On a clock edge the grant stays put when the granted initiator has cycle high together with either lock high or strobe high.
- R4: If the granted initiator holds cycle high with lock and strobe both low, and another initiator is requesting, the grant moves on the next edge.
- R5: When the grant is released, the new grant goes to the first initiator with cycle high, searching from the current index plus one and wrapping around. If no initiator requests, the grant is unchanged.
- R6: Acknowledge, error, retry and read data reach only the granted initiator. Every other initiator sees zeros.
- R7: A non-granted initiator always sees stall = 1. The granted initiator sees the shared bus stall.
- R8: With the target stall input disabled (HAS_BUS_STALL = 0), the granted initiator sees stall = NOT acknowledge.
- R9: For an initiator without lock, the bus lock equals its cycle line. Without cycle-type, the bus gets 3'b000 (classic). Without burst extension, the bus gets 2'b00 (linear). The ignored inputs have no effect.
- R10: An initiator with granularity 2^k times the bus granularity drives bus select bit j from its select bit j>>k. For example, k=1 with select 2'b10 gives 4'b1100.
- R11: The data width and granularities must be 8, 16, 32 or 64. No granularity may exceed the data width. There must be at least two initiators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_cyc | input | N_INIT | Cycle (request) per initiator |
| init_stb | input | N_INIT | Strobe per initiator |
| init_we | input | N_INIT | Write enable per initiator |
| init_lock | input | N_INIT | Lock per initiator (ignored where absent) |
| init_adr | input | N_INIT*ADDR_W | Address per initiator |
| init_dat_w | input | N_INIT*DATA_W | Write data per initiator |
| init_sel | input | N_INIT*SEL_W | Byte selects per initiator, low bits used when coarser |
| init_cti | input | N_INIT*3 | Cycle type per initiator (ignored where absent) |
| init_bte | input | N_INIT*2 | Burst extension per initiator (ignored where absent) |
| init_dat_r | output | N_INIT*DATA_W | Read data per initiator |
| init_ack | output | N_INIT | Acknowledge per initiator |
| init_err | output | N_INIT | Error per initiator |
| init_rty | output | N_INIT | Retry per initiator |
| init_stall | output | N_INIT | Stall per initiator |
| bus_adr | output | ADDR_W | Shared bus address |
| bus_dat_w | output | DATA_W | Shared bus write data |
| bus_sel | output | SEL_W | Shared bus selects |
| bus_cyc | output | 1 | Shared bus cycle |
| bus_stb | output | 1 | Shared bus strobe |
| bus_we | output | 1 | Shared bus write enable |
| bus_lock | output | 1 | Shared bus lock |
| bus_cti | output | 3 | Shared bus cycle type |
| bus_bte | output | 2 | Shared bus burst extension |
| bus_dat_r | input | DATA_W | Target read data |
| bus_ack | input | 1 | Target acknowledge |
| bus_err | input | 1 | Target error |
| bus_rty | input | 1 | Target retry |
| bus_stall | input | 1 | Target stall (unused when HAS_BUS_STALL = 0) |

## Verification
Two behaviours can land in the same cycle. In one cycle a grant can be released and the next owner chosen, while the routing of responses must already follow the grant that was just registered. The vector table provokes this with rows where the owner drops its claim while other initiators raise cycle. In each such row the bench keeps the target acknowledge high and checks, just after the edge, that the acknowledge arrives one-hot at the initiator the rotation predicts. A second case pairs lock release with a live strobe: the grant must hold on the strobe alone, and move only when both are low.

// File: rtl/bra_pkg.sv
package bra_pkg;
   typedef logic [2:0] cti_t;
   typedef logic [1:0] bte_t;

   localparam cti_t CTI_CLASSIC = 3'b000;
   localparam bte_t BTE_LINEAR  = 2'b00;

   function automatic bit width_ok(input int w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction
endpackage

// File: rtl/bra_init_adapt.sv
module bra_init_adapt
   import bra_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BUS_GRAN  = 8,
   parameter int GRAN_LOG2 = 0,
   parameter bit HAS_LOCK  = 1'b1,
   parameter bit HAS_CTI   = 1'b1,
   parameter bit HAS_BTE   = 1'b1
) (
   input  logic                         cyc_i,
   input  logic                         lock_i,
   input  cti_t                         cti_i,
   input  bte_t                         bte_i,
   input  logic [DATA_W/BUS_GRAN-1:0]   sel_i,
   output logic                         lock_o,
   output cti_t                         cti_o,
   output bte_t                         bte_o,
   output logic [DATA_W/BUS_GRAN-1:0]   sel_o
);
   localparam int SEL_W  = DATA_W / BUS_GRAN;
   localparam int USED_W = SEL_W >> GRAN_LOG2;

   // lock substitution
   if (HAS_LOCK) begin : g_lock
      assign lock_o = lock_i;
   end else begin : g_lock_dflt
      logic unused_lock;
      assign unused_lock = lock_i;
      assign lock_o      = cyc_i;
   end

   if (HAS_CTI) begin : g_cti
      assign cti_o = cti_i;
   end else begin : g_cti_dflt
      logic unused_cti;
      assign unused_cti = ^cti_i;
      assign cti_o      = CTI_CLASSIC;
   end

   if (HAS_BTE) begin : g_bte
      assign bte_o = bte_i;
   end else begin : g_bte_dflt
      logic unused_bte;
      assign unused_bte = ^bte_i;
      assign bte_o      = BTE_LINEAR;
   end

   // select lane widening
   for (genvar j = 0; j < SEL_W; j++) begin : g_lane
      assign sel_o[j] = sel_i[j >> GRAN_LOG2];
   end

   if (GRAN_LOG2 > 0) begin : g_sel_spare
      logic unused_sel;
      assign unused_sel = ^sel_i[SEL_W-1:USED_W];
   end
endmodule

// File: rtl/bra_rr_pick.sv
module bra_rr_pick #(
   parameter int N_INIT = 3,
   localparam int GW    = $clog2(N_INIT)
) (
   input  logic [GW-1:0]     cur_i,
   input  logic [N_INIT-1:0] req_i,
   input  logic              hold_i,
   output logic [GW-1:0]     next_o
);
   logic          found;
   logic [GW-1:0] cand;

   always_comb begin
      cand  = cur_i;
      found = 1'b0;
      for (int k = 1; k <= N_INIT; k++) begin
         int idx;
         idx = (int'(cur_i) + k) % N_INIT;
         if (!found && req_i[idx]) begin
            cand  = GW'(idx);
            found = 1'b1;
         end
      end
      next_o = hold_i ? cur_i : cand;
   end
endmodule

// File: rtl/bus_rr_arbiter.sv
module bus_rr_arbiter
   import bra_pkg::*;
#(
   parameter int                  N_INIT         = 3,
   parameter int                  ADDR_W         = 30,
   parameter int                  DATA_W         = 32,
   parameter int                  BUS_GRAN       = 8,
   parameter logic [2*N_INIT-1:0] INIT_GRAN_LOG2 = '0,
   parameter logic [N_INIT-1:0]   INIT_HAS_LOCK  = '1,
   parameter logic [N_INIT-1:0]   INIT_HAS_CTI   = '1,
   parameter logic [N_INIT-1:0]   INIT_HAS_BTE   = '1,
   parameter bit                  HAS_BUS_STALL  = 1'b1,
   localparam int                 SEL_W          = DATA_W / BUS_GRAN
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [N_INIT-1:0]          init_cyc,
   input  logic [N_INIT-1:0]          init_stb,
   input  logic [N_INIT-1:0]          init_we,
   input  logic [N_INIT-1:0]          init_lock,
   input  logic [N_INIT*ADDR_W-1:0]   init_adr,
   input  logic [N_INIT*DATA_W-1:0]   init_dat_w,
   input  logic [N_INIT*SEL_W-1:0]    init_sel,
   input  logic [N_INIT*3-1:0]        init_cti,
   input  logic [N_INIT*2-1:0]        init_bte,
   output logic [N_INIT*DATA_W-1:0]   init_dat_r,
   output logic [N_INIT-1:0]          init_ack,
   output logic [N_INIT-1:0]          init_err,
   output logic [N_INIT-1:0]          init_rty,
   output logic [N_INIT-1:0]          init_stall,
   output logic [ADDR_W-1:0]          bus_adr,
   output logic [DATA_W-1:0]          bus_dat_w,
   output logic [SEL_W-1:0]           bus_sel,
   output logic                       bus_cyc,
   output logic                       bus_stb,
   output logic                       bus_we,
   output logic                       bus_lock,
   output logic [2:0]                 bus_cti,
   output logic [1:0]                 bus_bte,
   input  logic [DATA_W-1:0]          bus_dat_r,
   input  logic                       bus_ack,
   input  logic                       bus_err,
   input  logic                       bus_rty,
   input  logic                       bus_stall
);
   localparam int GW = $clog2(N_INIT);

   // R11 parameter legality
   initial begin
      assert (N_INIT >= 2) else $error("R11: need at least two initiators");
      assert (width_ok(DATA_W)) else $error("R11: bad data width %0d", DATA_W);
      assert (width_ok(BUS_GRAN) && BUS_GRAN <= DATA_W)
         else $error("R11: bad bus granularity %0d", BUS_GRAN);
   end

   logic [N_INIT-1:0]       lock_eff;
   logic [N_INIT-1:0][2:0]  cti_eff;
   logic [N_INIT-1:0][1:0]  bte_eff;
   logic [N_INIT-1:0][SEL_W-1:0] sel_eff;
   logic [N_INIT-1:0]       gsel;

   logic [GW-1:0] grant_q;
   logic [GW-1:0] grant_d;
   logic          cur_cyc, cur_stb, cur_lock, hold;

   for (genvar i = 0; i < N_INIT; i++) begin : g_init
      localparam int GL = int'(INIT_GRAN_LOG2[2*i +: 2]);

      initial begin
         assert (width_ok(BUS_GRAN << GL) && (BUS_GRAN << GL) <= DATA_W)
            else $error("R11: initiator %0d granularity too wide", i);
      end

      bra_init_adapt #(
         .DATA_W   (DATA_W),
         .BUS_GRAN (BUS_GRAN),
         .GRAN_LOG2(GL),
         .HAS_LOCK (INIT_HAS_LOCK[i]),
         .HAS_CTI  (INIT_HAS_CTI[i]),
         .HAS_BTE  (INIT_HAS_BTE[i])
      ) i_adapt (
         .cyc_i (init_cyc[i]),
         .lock_i(init_lock[i]),
         .cti_i (init_cti[3*i +: 3]),
         .bte_i (init_bte[2*i +: 2]),
         .sel_i (init_sel[SEL_W*i +: SEL_W]),
         .lock_o(lock_eff[i]),
         .cti_o (cti_eff[i]),
         .bte_o (bte_eff[i]),
         .sel_o (sel_eff[i])
      );

      assign gsel[i] = (grant_q == GW'(i));

      // response routing
      assign init_ack[i] = gsel[i] & bus_ack;
      assign init_err[i] = gsel[i] & bus_err;
      assign init_rty[i] = gsel[i] & bus_rty;
      assign init_dat_r[DATA_W*i +: DATA_W] = gsel[i] ? bus_dat_r : '0;
   end

   // stall source
   logic stall_src;
   if (HAS_BUS_STALL) begin : g_stall
      assign stall_src = bus_stall;
   end else begin : g_stall_emul
      logic unused_stall;
      assign unused_stall = bus_stall;
      assign stall_src    = ~bus_ack;
   end

   for (genvar i = 0; i < N_INIT; i++) begin : g_stall_out
      assign init_stall[i] = gsel[i] ? stall_src : 1'b1;
   end

   // forward path multiplexer
   always_comb begin
      bus_adr   = '0;
      bus_dat_w = '0;
      bus_sel   = '0;
      bus_cyc   = 1'b0;
      bus_stb   = 1'b0;
      bus_we    = 1'b0;
      bus_lock  = 1'b0;
      bus_cti   = CTI_CLASSIC;
      bus_bte   = BTE_LINEAR;
      for (int i = 0; i < N_INIT; i++) begin
         if (gsel[i]) begin
            bus_adr   = init_adr[ADDR_W*i +: ADDR_W];
            bus_dat_w = init_dat_w[DATA_W*i +: DATA_W];
            bus_sel   = sel_eff[i];
            bus_cyc   = init_cyc[i];
            bus_stb   = init_stb[i];
            bus_we    = init_we[i];
            bus_lock  = lock_eff[i];
            bus_cti   = cti_eff[i];
            bus_bte   = bte_eff[i];
         end
      end
   end

   assign cur_cyc  = bus_cyc;
   assign cur_stb  = bus_stb;
   assign cur_lock = bus_lock;
   assign hold     = cur_cyc & (cur_lock | cur_stb);

   bra_rr_pick #(.N_INIT(N_INIT)) i_pick (
      .cur_i (grant_q),
      .req_i (init_cyc),
      .hold_i(hold),
      .next_o(grant_d)
   );

   always_ff @(posedge clk) begin
      if (rst) grant_q <= '0;
      else     grant_q <= grant_d;
   end

   // assertions
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (cur_cyc && (cur_lock || cur_stb)) |=> $stable(grant_q));

   p_release_r4: assert property (@(posedge clk) disable iff (rst)
      (cur_cyc && !cur_lock && !cur_stb && $countones(init_cyc) > 1)
         |=> !$stable(grant_q));

   p_idle_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (init_cyc == '0) |=> $stable(grant_q));

   p_resp_onehot_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(init_ack) && $onehot0(init_err) && $onehot0(init_rty));

   p_stall_others_r7: assert property (@(posedge clk) disable iff (rst)
      $countones(init_stall) >= N_INIT - 1);

   p_bus_cyc_src_r2: assert property (@(posedge clk) disable iff (rst)
      bus_cyc |-> (init_cyc != '0));
endmodule

// File: tb/test_bus_rr_arbiter.sv
module test_bus_rr_arbiter;
   localparam int N  = 3;
   localparam int AW = 30;
   localparam int DW = 32;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [N-1:0]      cyc = '0, stb = '0, we = '0, lock = '0;
   logic [N*AW-1:0]   adr = '0;
   logic [N*DW-1:0]   dat_w = '0;
   logic [N*SW-1:0]   sel = '0;
   logic [N*3-1:0]    cti = '0;
   logic [N*2-1:0]    bte = '0;
   logic [DW-1:0]     b_dat_r = '0;
   logic              b_ack = 1'b0, b_err = 1'b0, b_rty = 1'b0, b_stall = 1'b0;

   logic [N*DW-1:0]   o_dat_r, n_dat_r;
   logic [N-1:0]      o_ack, o_err, o_rty, o_stall;
   logic [N-1:0]      n_ack, n_err, n_rty, n_stall;
   logic [AW-1:0]     o_adr, n_adr;
   logic [DW-1:0]     o_dat_w, n_dat_w;
   logic [SW-1:0]     o_sel, n_sel;
   logic              o_cyc, o_stb, o_we, o_lock, n_cyc, n_stb, n_we, n_lock;
   logic [2:0]        o_cti, n_cti;
   logic [1:0]        o_bte, n_bte;

   // initiator 1: 16-bit granularity, has lock/cti/bte; others plain
   bus_rr_arbiter #(
      .N_INIT(N), .ADDR_W(AW), .DATA_W(DW), .BUS_GRAN(8),
      .INIT_GRAN_LOG2(6'b00_01_00), .INIT_HAS_LOCK(3'b010),
      .INIT_HAS_CTI(3'b010), .INIT_HAS_BTE(3'b010), .HAS_BUS_STALL(1'b1)
   ) i_bus_rr_arbiter (
      .clk, .rst, .init_cyc(cyc), .init_stb(stb), .init_we(we), .init_lock(lock),
      .init_adr(adr), .init_dat_w(dat_w), .init_sel(sel), .init_cti(cti), .init_bte(bte),
      .init_dat_r(o_dat_r), .init_ack(o_ack), .init_err(o_err), .init_rty(o_rty),
      .init_stall(o_stall), .bus_adr(o_adr), .bus_dat_w(o_dat_w), .bus_sel(o_sel),
      .bus_cyc(o_cyc), .bus_stb(o_stb), .bus_we(o_we), .bus_lock(o_lock),
      .bus_cti(o_cti), .bus_bte(o_bte), .bus_dat_r(b_dat_r), .bus_ack(b_ack),
      .bus_err(b_err), .bus_rty(b_rty), .bus_stall(b_stall)
   );

   bus_rr_arbiter #(
      .N_INIT(N), .ADDR_W(AW), .DATA_W(DW), .BUS_GRAN(8),
      .INIT_GRAN_LOG2(6'b00_01_00), .INIT_HAS_LOCK(3'b010),
      .INIT_HAS_CTI(3'b010), .INIT_HAS_BTE(3'b010), .HAS_BUS_STALL(1'b0)
   ) i_bus_rr_arbiter_nostall (
      .clk, .rst, .init_cyc(cyc), .init_stb(stb), .init_we(we), .init_lock(lock),
      .init_adr(adr), .init_dat_w(dat_w), .init_sel(sel), .init_cti(cti), .init_bte(bte),
      .init_dat_r(n_dat_r), .init_ack(n_ack), .init_err(n_err), .init_rty(n_rty),
      .init_stall(n_stall), .bus_adr(n_adr), .bus_dat_w(n_dat_w), .bus_sel(n_sel),
      .bus_cyc(n_cyc), .bus_stb(n_stb), .bus_we(n_we), .bus_lock(n_lock),
      .bus_cti(n_cti), .bus_bte(n_bte), .bus_dat_r(b_dat_r), .bus_ack(b_ack),
      .bus_err(b_err), .bus_rty(b_rty), .bus_stall(b_stall)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic edge_sample();
      @(posedge clk);
      #2;
   endtask

   // row: cyc[2:0], stb[2:0], lock1, expected grant[1:0]
   localparam int NV = 12;
   localparam logic [8:0] VEC [NV] = '{
      {3'b101, 3'b000, 1'b0, 2'd0},  // R3 no-lock initiator holds on cyc
      {3'b100, 3'b000, 1'b0, 2'd2},  // R5 skip idle 1
      {3'b110, 3'b000, 1'b0, 2'd2},  // R3 hold
      {3'b011, 3'b000, 1'b0, 2'd0},  // R5 wrap to 0
      {3'b010, 3'b000, 1'b0, 2'd1},  // R5
      {3'b111, 3'b000, 1'b1, 2'd1},  // R3 lock holds
      {3'b111, 3'b010, 1'b0, 2'd1},  // R3 strobe holds
      {3'b111, 3'b000, 1'b0, 2'd2},  // R4 release with cyc high
      {3'b000, 3'b000, 1'b0, 2'd2},  // R5 nobody: keep
      {3'b010, 3'b000, 1'b0, 2'd1},  // R5
      {3'b010, 3'b000, 1'b0, 2'd1},  // R4/R5 sole requester keeps it
      {3'b001, 3'b000, 1'b0, 2'd0}   // R5
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      cyc   = 3'b001;
      b_ack = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 grant0 ack", 64'(o_ack), 64'(3'b001));
      chk("R1 bus_cyc follows init0", 64'(o_cyc), 64'(1'b1));
      @(negedge clk);
      rst = 1'b0;
      edge_sample();
      chk("R1 grant after release", 64'(o_ack), 64'(3'b001));

      // R2 forwarding from initiator 0
      adr[0 +: AW]   = 30'h1234567;
      dat_w[0 +: DW] = 32'hcafe0011;
      stb[0] = 1'b1;
      we[0]  = 1'b1;
      #1;
      chk("R2 adr", 64'(o_adr), 64'(30'h1234567));
      chk("R2 dat_w", 64'(o_dat_w), 64'(32'hcafe0011));
      chk("R2 stb/we/cyc", 64'({o_stb, o_we, o_cyc}), 64'(3'b111));

      // R9 defaults on initiator 0 (no lock/cti/bte)
      cti[2:0] = 3'b010;
      bte[1:0] = 2'b01;
      lock[0]  = 1'b0;
      #1;
      chk("R9 cti default", 64'(o_cti), 64'(3'b000));
      chk("R9 bte default", 64'(o_bte), 64'(2'b00));
      chk("R9 lock equals cyc", 64'(o_lock), 64'(1'b1));

      // R10 plain lanes for initiator 0
      sel[3:0] = 4'b0101;
      #1;
      chk("R10 sel same granularity", 64'(o_sel), 64'(4'b0101));

      // R6 response routing
      b_dat_r = 32'h5a5a1234;
      b_err = 1'b1;
      b_rty = 1'b1;
      #1;
      chk("R6 dat_r granted", 64'(o_dat_r[0 +: DW]), 64'(32'h5a5a1234));
      chk("R6 dat_r others", 64'(o_dat_r[DW +: 2*DW]), 64'(0));
      chk("R6 err/rty", 64'({o_err, o_rty}), 64'(6'b001_001));
      b_err = 1'b0;
      b_rty = 1'b0;

      // R7 stall routing
      b_stall = 1'b0;
      #1;
      chk("R7 stall low", 64'(o_stall), 64'(3'b110));
      b_stall = 1'b1;
      #1;
      chk("R7 stall high", 64'(o_stall), 64'(3'b111));

      // R8 emulated stall
      b_stall = 1'b0;
      b_ack   = 1'b0;
      #1;
      chk("R8 no ack stalls", 64'(n_stall), 64'(3'b111));
      b_ack = 1'b1;
      #1;
      chk("R8 ack clears stall", 64'(n_stall), 64'(3'b110));

      // vector table of rotation scenarios
      stb  = '0;
      @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         cyc     = VEC[v][8:6];
         stb     = VEC[v][5:3];
         lock[1] = VEC[v][2];
         edge_sample();
         chk($sformatf("R3/R4/R5 row %0d ack", v), 64'(o_ack), 64'(3'b001 << VEC[v][1:0]));
         chk($sformatf("R2 row %0d bus_cyc", v), 64'(o_cyc), 64'(VEC[v][6 + VEC[v][1:0]]));
         @(negedge clk);
      end

      // move grant to initiator 1 and check its pass-through
      cyc = 3'b010;
      edge_sample();
      chk("R5 grant1", 64'(o_ack), 64'(3'b010));
      sel[7:4] = 4'b0010;
      cti[5:3] = 3'b010;
      bte[3:2] = 2'b01;
      lock[1]  = 1'b0;
      #1;
      chk("R10 widened sel", 64'(o_sel), 64'(4'b1100));
      chk("R9 cti passes", 64'(o_cti), 64'(3'b010));
      chk("R9 bte passes", 64'(o_bte), 64'(2'b01));
      chk("R9 real lock used", 64'(o_lock), 64'(1'b0));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule